// File: doc/BRIEF.md
# Segmented Bus Inversion Codec

This block encodes and decodes a wide data word for a bus whose lanes are grouped into equal segments. Each segment has its own active-low inversion flag. On the transmit side, the encoder counts the zero bits in each segment. When the zeros are a strict majority, it sends the complemented segment and drives that segment's flag low. This keeps the number of lines pulled low on the bus at or below half per segment.

On the receive side, the decoder complements every segment whose flag arrives low and passes the other segments through untouched. Because both agents on the bus apply the same rule, one instance can sit at either end of the link. Each direction is a registered path with one cycle of latency and a valid bit that travels with the data. The registered outputs hold their values between valid words.

The design has no state machine. Each path has exactly one register stage, loaded when its input valid is high and held otherwise.

Top module: `segbus_inv_codec`

## Requirements
- R1: While rst_n is low and after its release, tx_valid_o and rx_valid_o are 0, tx_bus_o and rx_data_o are all zeros, and tx_flag_n_o is all ones (no segment inverted).
- R2: A word presented with tx_valid_i high appears on tx_bus_o and tx_flag_n_o, with tx_valid_o high, exactly one clock later. tx_valid_o is low one clock after a cycle with tx_valid_i low.
- R3: A transmit segment with more than 8 of its 16 bits at 0 is sent bitwise inverted, and its flag is driven 0.
- R4: A transmit segment with exactly 8 zero bits is sent unchanged, and its flag is driven 1.
- R5: A transmit segment with fewer than 8 zero bits is sent unchanged, and its flag is driven 1.
- R6: Flag bit n covers data bits 16n+15 down to 16n. The decision for each segment depends only on that segment's bits.
- R7: On receive, a segment whose flag bit is 0 is inverted and a segment whose flag bit is 1 is passed unchanged. The result appears on rx_data_o one clock after rx_valid_i, with rx_valid_o high. rx_valid_o is low one clock after a cycle with rx_valid_i low.
- R8: While a path's input valid is low, its data and flag outputs keep their last values, whatever the data inputs carry.
- R9: Feeding tx_bus_o and tx_flag_n_o into the receive inputs returns the original 64-bit word, for any word.
- R10: Every valid transmitted segment carries at most 8 zero bits. A segment flagged as inverted carries strictly more ones than zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_valid_i | input | 1 | Transmit word valid |
| tx_data_i | input | 64 | Raw transmit word |
| tx_valid_o | output | 1 | Encoded word valid |
| tx_bus_o | output | 64 | Encoded bus data |
| tx_flag_n_o | output | 4 | Active-low inversion flags, bit n for segment n |
| rx_valid_i | input | 1 | Received word valid |
| rx_bus_i | input | 64 | Received bus data |
| rx_flag_n_i | input | 4 | Received active-low inversion flags |
| rx_valid_o | output | 1 | Decoded word valid |
| rx_data_o | output | 64 | Decoded word |

## Verification
The bench builds the codec with its defaults, four segments of 16 bits. With these values, the tie case of exactly 8 zeros and the case of 9 zeros sit next to each other and can be driven directly. With four segments, patterns that mix inverted and plain segments show that each flag governs only its own bit range. Round trips through both paths, using all-zero, all-one, walking and pseudo-random words, check that decoding undoes encoding for every flag combination.

// File: rtl/segbus_pkg.sv
package segbus_pkg;
    localparam int unsigned SEG_W_DEFAULT = 16;
    localparam int unsigned SEG_N_DEFAULT = 4;
endpackage

// File: rtl/segbus_seg_enc.sv
module segbus_seg_enc #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] raw,
    output logic [W-1:0] coded,
    output logic         flag_n
);
    localparam int unsigned CW = $clog2(W + 1);
    localparam int unsigned HALF = W / 2;

    logic [CW-1:0] zeros;

    always_comb begin
        zeros = '0;
        for (int i = 0; i < W; i++) begin
            zeros = zeros + CW'(~raw[i]);
        end
    end

    always_comb begin
        if (zeros > CW'(HALF)) begin
            coded  = ~raw;
            flag_n = 1'b0;
        end else begin
            coded  = raw;
            flag_n = 1'b1;
        end
    end
endmodule

// File: rtl/segbus_tx.sv
module segbus_tx #(
    parameter int unsigned SEG_W = 16,
    parameter int unsigned SEG_N = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tx_valid_i,
    input  logic [SEG_W*SEG_N-1:0] tx_data_i,
    output logic                   tx_valid_o,
    output logic [SEG_W*SEG_N-1:0] tx_bus_o,
    output logic [SEG_N-1:0]       tx_flag_n_o
);
    localparam int unsigned DW = SEG_W * SEG_N;

    logic [DW-1:0]    enc_data;
    logic [SEG_N-1:0] enc_flag_n;

    for (genvar g = 0; g < SEG_N; g++) begin : g_seg
        segbus_seg_enc #(.W(SEG_W)) u_enc (
            .raw    (tx_data_i[g*SEG_W +: SEG_W]),
            .coded  (enc_data[g*SEG_W +: SEG_W]),
            .flag_n (enc_flag_n[g])
        );

        // R10
        seg_zero_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            tx_valid_o |-> ($countones(tx_bus_o[g*SEG_W +: SEG_W]) >= int'(SEG_W / 2)));

        // R10
        seg_inverted_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (tx_valid_o && !tx_flag_n_o[g]) |->
                ($countones(tx_bus_o[g*SEG_W +: SEG_W]) > int'(SEG_W / 2)));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid_o  <= 1'b0;
            tx_bus_o    <= '0;
            tx_flag_n_o <= '1;
        end else begin
            tx_valid_o <= tx_valid_i;
            if (tx_valid_i) begin
                tx_bus_o    <= enc_data;
                tx_flag_n_o <= enc_flag_n;
            end
        end
    end

    // R2
    tx_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid_i |=> tx_valid_o);

    // R8
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_valid_i |=> ($stable(tx_bus_o) && $stable(tx_flag_n_o) && !tx_valid_o));
endmodule

// File: rtl/segbus_rx.sv
module segbus_rx #(
    parameter int unsigned SEG_W = 16,
    parameter int unsigned SEG_N = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rx_valid_i,
    input  logic [SEG_W*SEG_N-1:0] rx_bus_i,
    input  logic [SEG_N-1:0]       rx_flag_n_i,
    output logic                   rx_valid_o,
    output logic [SEG_W*SEG_N-1:0] rx_data_o
);
    localparam int unsigned DW = SEG_W * SEG_N;

    logic [DW-1:0] dec_data;

    for (genvar g = 0; g < SEG_N; g++) begin : g_seg
        assign dec_data[g*SEG_W +: SEG_W] =
            rx_bus_i[g*SEG_W +: SEG_W] ^ {SEG_W{~rx_flag_n_i[g]}};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_valid_o <= 1'b0;
            rx_data_o  <= '0;
        end else begin
            rx_valid_o <= rx_valid_i;
            if (rx_valid_i) begin
                rx_data_o <= dec_data;
            end
        end
    end

    // R7
    rx_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_i |=> rx_valid_o);

    // R8
    rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid_i |=> ($stable(rx_data_o) && !rx_valid_o));
endmodule

// File: rtl/segbus_inv_codec.sv
module segbus_inv_codec
    import segbus_pkg::*;
#(
    parameter int unsigned SEG_W = SEG_W_DEFAULT,
    parameter int unsigned SEG_N = SEG_N_DEFAULT
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tx_valid_i,
    input  logic [SEG_W*SEG_N-1:0] tx_data_i,
    output logic                   tx_valid_o,
    output logic [SEG_W*SEG_N-1:0] tx_bus_o,
    output logic [SEG_N-1:0]       tx_flag_n_o,
    input  logic                   rx_valid_i,
    input  logic [SEG_W*SEG_N-1:0] rx_bus_i,
    input  logic [SEG_N-1:0]       rx_flag_n_i,
    output logic                   rx_valid_o,
    output logic [SEG_W*SEG_N-1:0] rx_data_o
);
    segbus_tx #(.SEG_W(SEG_W), .SEG_N(SEG_N)) u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_valid_i  (tx_valid_i),
        .tx_data_i   (tx_data_i),
        .tx_valid_o  (tx_valid_o),
        .tx_bus_o    (tx_bus_o),
        .tx_flag_n_o (tx_flag_n_o)
    );

    segbus_rx #(.SEG_W(SEG_W), .SEG_N(SEG_N)) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_valid_i  (rx_valid_i),
        .rx_bus_i    (rx_bus_i),
        .rx_flag_n_i (rx_flag_n_i),
        .rx_valid_o  (rx_valid_o),
        .rx_data_o   (rx_data_o)
    );
endmodule

// File: tb/segbus_inv_codec_test.sv
`timescale 1ns/1ps
module segbus_inv_codec_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        tx_valid_i;
    logic [63:0] tx_data_i;
    logic        tx_valid_o;
    logic [63:0] tx_bus_o;
    logic [3:0]  tx_flag_n_o;
    logic        rx_valid_i;
    logic [63:0] rx_bus_i;
    logic [3:0]  rx_flag_n_i;
    logic        rx_valid_o;
    logic [63:0] rx_data_o;

    int n_checks = 0;
    int n_fails  = 0;

    always #2.5 clk = ~clk;

    segbus_inv_codec uut (
        .clk(clk), .rst_n(rst_n),
        .tx_valid_i(tx_valid_i), .tx_data_i(tx_data_i),
        .tx_valid_o(tx_valid_o), .tx_bus_o(tx_bus_o), .tx_flag_n_o(tx_flag_n_o),
        .rx_valid_i(rx_valid_i), .rx_bus_i(rx_bus_i), .rx_flag_n_i(rx_flag_n_i),
        .rx_valid_o(rx_valid_o), .rx_data_o(rx_data_o)
    );

    task automatic check(input string req, input logic [67:0] act, input logic [67:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [67:0] model_enc(input logic [63:0] d);
        logic [63:0] b;
        logic [3:0]  f;
        for (int s = 0; s < 4; s++) begin
            int z = 0;
            for (int i = 0; i < 16; i++) z += (d[s*16+i] == 1'b0) ? 1 : 0;
            if (z > 8) begin
                b[s*16 +: 16] = ~d[s*16 +: 16];
                f[s] = 1'b0;
            end else begin
                b[s*16 +: 16] = d[s*16 +: 16];
                f[s] = 1'b1;
            end
        end
        return {f, b};
    endfunction

    task automatic encode_check(input string req, input logic [63:0] d);
        @(negedge clk);
        tx_valid_i = 1'b1;
        tx_data_i  = d;
        @(negedge clk);
        tx_valid_i = 1'b0;
        check({req, " valid"}, {67'd0, tx_valid_o}, 68'd1);
        check(req, {tx_flag_n_o, tx_bus_o}, model_enc(d));
    endtask

    task automatic round_trip(input string req, input logic [63:0] d);
        encode_check(req, d);
        rx_valid_i  = 1'b1;
        rx_bus_i    = tx_bus_o;
        rx_flag_n_i = tx_flag_n_o;
        @(negedge clk);
        rx_valid_i = 1'b0;
        check({req, " rx valid"}, {67'd0, rx_valid_o}, 68'd1);
        check(req, {4'd0, rx_data_o}, {4'd0, d});
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        tx_valid_i = 1'b0; tx_data_i = '0;
        rx_valid_i = 1'b0; rx_bus_i = '0; rx_flag_n_i = '1;
        repeat (3) @(negedge clk);
        check("R1 tx", {tx_valid_o, tx_flag_n_o, tx_bus_o[62:0]}, {1'b0, 4'hF, 63'd0});
        check("R1 rx", {3'd0, rx_valid_o, rx_data_o}, 68'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {tx_valid_o, rx_valid_o, tx_flag_n_o, 62'd0},
              {1'b0, 1'b0, 4'hF, 62'd0});
    endtask

    task automatic test_thresholds();
        // seg3 9 zeros -> FF80 flag0; seg2 8 zeros plain; seg1 no zeros; seg0 all zeros
        encode_check("R3 R4 R6 mixed", 64'h007F_00FF_FFFF_0000);
        check("R6 flags", {64'd0, tx_flag_n_o}, {64'd0, 4'b0110});
        check("R3 seg3", {52'd0, tx_bus_o[63:48]}, {52'd0, 16'hFF80});
        check("R4 seg2", {52'd0, tx_bus_o[47:32]}, {52'd0, 16'h00FF});
        encode_check("R4 tie all segs", 64'hAAAA_5555_F0F0_0F0F);
        check("R4 flags", {64'd0, tx_flag_n_o}, {64'd0, 4'hF});
        encode_check("R5 few zeros", 64'hFFFE_7FFF_FEFF_EFFF);
        encode_check("R3 all zero", 64'h0);
        check("R3 flags", {64'd0, tx_flag_n_o}, {64'd0, 4'h0});
        for (int s = 0; s < 4; s++) begin
            logic [63:0] d = 64'hFFFF_FFFF_FFFF_FFFF;
            d[s*16 +: 16] = 16'h0001;
            encode_check("R6 single seg", d);
            check("R6 single flag", {64'd0, tx_flag_n_o}, {64'd0, ~(4'b1 << s)});
        end
    endtask

    task automatic test_tx_idle();
        logic [67:0] held;
        encode_check("R2 load", 64'h0000_1234_FFFF_8000);
        held = {tx_flag_n_o, tx_bus_o};
        tx_data_i = 64'hFFFF_FFFF_FFFF_FFFF;
        repeat (3) @(negedge clk);
        check("R2 valid low", {67'd0, tx_valid_o}, 68'd0);
        check("R8 tx hold", {tx_flag_n_o, tx_bus_o}, held);
    endtask

    task automatic test_rx_direct();
        @(negedge clk);
        rx_valid_i  = 1'b1;
        rx_bus_i    = 64'h1234_5678_9ABC_DEF0;
        rx_flag_n_i = 4'b1010;
        @(negedge clk);
        rx_valid_i = 1'b0;
        check("R7 decode", {4'd0, rx_data_o}, {4'd0, 64'h1234_A987_9ABC_210F});
        rx_bus_i    = 64'h0;
        rx_flag_n_i = 4'h0;
        repeat (2) @(negedge clk);
        check("R7 valid low", {67'd0, rx_valid_o}, 68'd0);
        check("R8 rx hold", {4'd0, rx_data_o}, {4'd0, 64'h1234_A987_9ABC_210F});
    endtask

    task automatic test_round_trip();
        round_trip("R9 zeros", 64'h0);
        round_trip("R9 ones", 64'hFFFF_FFFF_FFFF_FFFF);
        for (int i = 0; i < 64; i++) round_trip("R9 walk", 64'h1 << i);
        for (int i = 0; i < 200; i++) round_trip("R9 random", {$urandom, $urandom});
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        test_reset();
        test_thresholds();
        test_tx_idle();
        test_rx_direct();
        test_round_trip();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule